// File: doc/BRIEF.md
# Floating-Gain IQ Scaler with Output Clipping

This block applies one programmable signal gain to a complex sample stream. The gain is a 12-bit word in the log domain. Its upper four bits are an exponent that moves the sample left by 0 to 15 places, which is about 6.02 dB per step. Its lower eight bits are a mantissa that selects a fine factor of 2^(m/256) from an on-chip table, which gives steps of about 0.024 dB. The total range is 0 to about 96.3 dB. I and Q always receive the same gain.

The scaled result is held in a 19-bit intermediate with symmetric saturation. It is then reduced to one of eight output word lengths, chosen per sample, by clipping to the signed range of that length. The reduced value is sign-extended onto a 16-bit output port. A flag marks each output sample in which saturation happened.

The gain comes from one of two sources. One is a live value from the loop controller. The other is a held initial-gain register, which is used before the loop starts.

Top module: `iq_gain_scaler`

## Requirements
- R1: While reset is high, and at the first sample after reset, `out_valid`, `out_clip`, `out_i` and `out_q` are 0. The initial-gain register resets to 0x000, which is unity gain.
- R2: In a gain word, bits [11:8] are the exponent e and bits [7:0] are the mantissa m. The fine factor is F(m) = round(256·2^(m/256)), which runs from 256 to 511. Before reduction, the scaled value is floor(x·F(m)·2^e / 256). For example, x=1000 with gain 0x080 gives 1414, and x=-1000 with the same gain gives -1415.
- R3: The I and Q samples of one input cycle are scaled by the same gain word and come out in the same output cycle.
- R4: `out_len` is sampled with each input sample. It selects the output width W: codes 0 to 7 give 4, 5, 6, 7, 8, 10, 12 and 16 bits. The output saturates symmetrically to ±(2^(W-1)-1), so with W=4 the limits are +7 and -7, and the result is sign-extended to 16 bits.
- R5: `out_clip` is high in an output cycle only if `out_valid` is high and at least one lane saturated for that sample.
- R6: Every sample accepted with `in_valid` appears with `out_valid` exactly two clock cycles later. Back-to-back samples are supported at one sample per cycle.
- R7: With `loop_en`=1 the gain is `loop_gain`. With `loop_en`=0 the gain is the initial-gain register. The register loads `init_gain` on a cycle where `init_we` is high. A sample taken in that same cycle still uses the old register value.
- R8: Without an input sample, `out_valid` and `out_clip` stay low two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Signed in-phase sample |
| in_q | input | 16 | Signed quadrature sample |
| loop_en | input | 1 | 1 selects the loop gain, 0 selects the initial-gain register |
| loop_gain | input | 12 | Live gain word (exponent in [11:8], mantissa in [7:0]) |
| init_we | input | 1 | Load strobe for the initial-gain register |
| init_gain | input | 12 | Value loaded into the initial-gain register |
| out_len | input | 3 | Output word length code |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Scaled, clipped in-phase result |
| out_q | output | 16 | Scaled, clipped quadrature result |
| out_clip | output | 1 | Saturation occurred for this output sample |

## Verification
A wrong fine-table entry or a wrong exponent shift shows up on the very next output sample that uses that gain word. It appears as a value that is off by a factor or by a rounding step, and negative inputs expose errors in the floor direction. A misaligned pipeline stage shows up as an output two cycles late or early, or as I and Q taken from different gains. A stale initial-gain register shows up on the first sample taken with `loop_en` low. Clip errors appear as asymmetric limits or a flag that does not match the width of that same sample.

// File: rtl/iqs_pkg.sv
package iqs_pkg;

  localparam int EXP_W   = 4;
  localparam int MAN_W   = 8;
  localparam int GAIN_W  = EXP_W + MAN_W;
  localparam int LEN_W   = 3;

  // output word length selected by the length code
  function automatic int len_of(input logic [LEN_W-1:0] code);
    case (code)
      3'd0:    return 4;
      3'd1:    return 5;
      3'd2:    return 6;
      3'd3:    return 7;
      3'd4:    return 8;
      3'd5:    return 10;
      3'd6:    return 12;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/iqs_fine_rom.sv
module iqs_fine_rom #(
  parameter int MAN_W = 8,
  parameter int F_W   = MAN_W + 1
) (
  input  logic             clk,
  input  logic [MAN_W-1:0] addr,
  output logic [F_W-1:0]   data
);
  localparam int DEPTH = 1 << MAN_W;

  function automatic logic [F_W-1:0] fine_val(input int k);
    real scale;
    real v;
    scale = real'(DEPTH);
    v = scale * (2.0 ** (real'(k) / scale));
    return F_W'($rtoi(v + 0.5));
  endfunction

  logic [F_W-1:0] rom [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) rom[k] = fine_val(k);
  end

  // registered read so the table maps onto block memory
  always_ff @(posedge clk) data <= rom[addr];

endmodule

// File: rtl/iqs_lane.sv
module iqs_lane #(
  parameter int IN_W   = 16,
  parameter int F_W    = 9,
  parameter int FRAC_W = 8,
  parameter int EXP_W  = 4,
  parameter int WIDE_W = 19,
  parameter int OUT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  x,
  input  logic [F_W-1:0]          fine,
  input  logic [EXP_W-1:0]        e,
  input  logic [2:0]              code,
  output logic signed [OUT_W-1:0] y,
  output logic                    clip
);
  localparam int PROD_W = IN_W + F_W + 1;
  localparam int PW     = PROD_W + (1 << EXP_W) - 1;
  localparam logic signed [PW-1:0] WMAX = PW'((64'sd1 <<< (WIDE_W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] WMIN = -WMAX;

  logic signed [PROD_W-1:0] prod;
  logic signed [PW-1:0]     ext, sh, q;
  logic signed [WIDE_W-1:0] w19, lim, fin;
  logic                     sat_wide, sat_len;
  int                       wl;

  logic signed [WIDE_W-1:0] y_q, lim_q;
  logic                     clip_q;

  always_comb begin
    prod = x * $signed({1'b0, fine});
    ext  = PW'(prod);
    sh   = ext <<< e;
    q    = sh >>> FRAC_W;
    // 19-bit intermediate, symmetric saturation
    sat_wide = 1'b0;
    if (q > WMAX) begin
      w19 = WMAX[WIDE_W-1:0];
      sat_wide = 1'b1;
    end else if (q < WMIN) begin
      w19 = WMIN[WIDE_W-1:0];
      sat_wide = 1'b1;
    end else begin
      w19 = q[WIDE_W-1:0];
    end
    // reduction to the selected word length
    wl  = iqs_pkg::len_of(code);
    lim = WIDE_W'((32'sd1 <<< (wl - 1)) - 32'sd1);
    sat_len = 1'b0;
    if (w19 > lim) begin
      fin = lim;
      sat_len = 1'b1;
    end else if (w19 < -lim) begin
      fin = -lim;
      sat_len = 1'b1;
    end else begin
      fin = w19;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q    <= '0;
      lim_q  <= '0;
      clip_q <= 1'b0;
    end else begin
      y_q    <= fin;
      lim_q  <= lim;
      clip_q <= en & (sat_wide | sat_len);
    end
  end

  assign y    = y_q[OUT_W-1:0];
  assign clip = clip_q;

  // R4: result never leaves the symmetric range of its word length
  assert_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    (y_q <= lim_q) && (y_q >= -lim_q));

  // R4: a saturated sample sits exactly on one of the two limits
  assert_clip_at_limit_R4: assert property (@(posedge clk) disable iff (rst)
    clip_q |-> ((y_q == lim_q) || (y_q == -lim_q)));

endmodule

// File: rtl/iq_gain_scaler.sv
module iq_gain_scaler #(
  parameter int IN_W   = 16,
  parameter int WIDE_W = 19,
  parameter int OUT_W  = 16
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       in_valid,
  input  logic signed [IN_W-1:0]                     in_i,
  input  logic signed [IN_W-1:0]                     in_q,
  input  logic                                       loop_en,
  input  logic [iqs_pkg::GAIN_W-1:0]                 loop_gain,
  input  logic                                       init_we,
  input  logic [iqs_pkg::GAIN_W-1:0]                 init_gain,
  input  logic [iqs_pkg::LEN_W-1:0]                  out_len,
  output logic                                       out_valid,
  output logic signed [OUT_W-1:0]                    out_i,
  output logic signed [OUT_W-1:0]                    out_q,
  output logic                                       out_clip
);
  localparam int EXP_W  = iqs_pkg::EXP_W;
  localparam int MAN_W  = iqs_pkg::MAN_W;
  localparam int GAIN_W = iqs_pkg::GAIN_W;
  localparam int LEN_W  = iqs_pkg::LEN_W;
  localparam int F_W    = MAN_W + 1;
  localparam int LANES  = 2;

  logic [GAIN_W-1:0] init_q, gain_sel;
  logic              s1_valid;
  logic [EXP_W-1:0]  s1_e;
  logic [LEN_W-1:0]  s1_len;
  logic [F_W-1:0]    s1_fine;

  logic signed [IN_W-1:0]  in_x   [LANES];
  logic signed [IN_W-1:0]  s1_x   [LANES];
  logic signed [OUT_W-1:0] lane_y [LANES];
  logic                    lane_c [LANES];

  assign gain_sel = loop_en ? loop_gain : init_q;
  assign in_x[0]  = in_i;
  assign in_x[1]  = in_q;

  always_ff @(posedge clk) begin
    if (rst)          init_q <= '0;
    else if (init_we) init_q <= init_gain;
  end

  iqs_fine_rom #(.MAN_W(MAN_W), .F_W(F_W)) u_rom (
    .clk  (clk),
    .addr (gain_sel[MAN_W-1:0]),
    .data (s1_fine)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_e      <= '0;
      s1_len    <= '0;
      out_valid <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      s1_e      <= gain_sel[GAIN_W-1 -: EXP_W];
      s1_len    <= out_len;
      out_valid <= s1_valid;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) s1_x[g] <= '0;
      else     s1_x[g] <= in_x[g];
    end

    iqs_lane #(
      .IN_W(IN_W), .F_W(F_W), .FRAC_W(MAN_W), .EXP_W(EXP_W),
      .WIDE_W(WIDE_W), .OUT_W(OUT_W)
    ) u_lane (
      .clk  (clk),
      .rst  (rst),
      .en   (s1_valid),
      .x    (s1_x[g]),
      .fine (s1_fine),
      .e    (s1_e),
      .code (s1_len),
      .y    (lane_y[g]),
      .clip (lane_c[g])
    );
  end

  assign out_i    = lane_y[0];
  assign out_q    = lane_y[1];
  assign out_clip = lane_c[0] | lane_c[1];

  // R6: fixed two-cycle latency from accepted sample to output strobe
  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R8: no output strobe without a sample two cycles earlier
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  // R5: the clip flag only accompanies a valid output
  assert_clip_valid_R5: assert property (@(posedge clk) disable iff (rst)
    out_clip |-> out_valid);

endmodule

// File: tb/iq_gain_scaler_test.sv
`timescale 1ns/1ps
module iq_gain_scaler_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic loop_en = 1'b1;
  logic [11:0] loop_gain = '0, init_gain = '0;
  logic init_we = 1'b0;
  logic [2:0] out_len = 3'd7;
  logic out_valid, out_clip;
  logic signed [15:0] out_i, out_q;

  always #5 clk = ~clk;

  iq_gain_scaler uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .loop_en(loop_en), .loop_gain(loop_gain), .init_we(init_we),
    .init_gain(init_gain), .out_len(out_len), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .out_clip(out_clip)
  );

  typedef struct {
    int ei; int eq; bit ec; int t; string tag;
  } exp_t;

  exp_t sb[$];
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [11:0] init_m = 12'h000;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int fine(input int m);
    return $rtoi(256.0 * (2.0 ** (real'(m) / 256.0)) + 0.5);
  endfunction

  function automatic int width_of(input int c);
    int t[8] = '{4, 5, 6, 7, 8, 10, 12, 16};
    return t[c];
  endfunction

  task automatic model(input int x, input logic [11:0] g, input int c,
                       output int y, output bit cl);
    longint p, s, lim;
    p = longint'(x) * longint'(fine(int'(g[7:0]))) * (longint'(1) << g[11:8]);
    s = p >>> 8;
    cl = 0;
    if (s > 262143) begin s = 262143; cl = 1; end
    if (s < -262143) begin s = -262143; cl = 1; end
    lim = (longint'(1) << (width_of(c) - 1)) - 1;
    if (s > lim) begin s = lim; cl = 1; end
    if (s < -lim) begin s = -lim; cl = 1; end
    y = int'(s);
  endtask

  task automatic step(input bit v, input int i, input int q, input bit le,
                      input logic [11:0] lg, input bit we, input logic [11:0] wg,
                      input int c, input bit known, input int ki, input int kq,
                      input bit kc, input string tag);
    exp_t e;
    logic [11:0] g;
    int yi, yq;
    bit ci, cq;
    @(negedge clk);
    in_valid = v; in_i = 16'(i); in_q = 16'(q); loop_en = le; loop_gain = lg;
    init_we = we; init_gain = wg; out_len = 3'(c);
    if (v) begin
      if (known) begin
        e.ei = ki; e.eq = kq; e.ec = kc;
      end else begin
        g = le ? lg : init_m;
        model(i, g, c, yi, ci);
        model(q, g, c, yq, cq);
        e.ei = yi; e.eq = yq; e.ec = ci | cq;
      end
      e.t = cyc; e.tag = tag;
      sb.push_back(e);
    end
    if (we) init_m = wg;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++)
      step(0, 0, 0, 1, 12'h000, 0, 12'h000, 7, 0, 0, 0, 0, "");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (!rst && out_valid) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R8: unexpected out_valid, got i=%0d q=%0d expected none", out_i, out_q);
      end else begin
        e = sb.pop_front();
        if (int'(out_i) != e.ei || int'(out_q) != e.eq || out_clip != e.ec ||
            cyc != e.t + 2) begin
          bad++;
          $display("FAIL %s: got i=%0d q=%0d clip=%0d lat=%0d expected i=%0d q=%0d clip=%0d lat=2",
                   e.tag, out_i, out_q, out_clip, cyc - e.t, e.ei, e.eq, e.ec);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    total++;
    if (out_valid !== 1'b0 || out_clip !== 1'b0 || out_i !== 16'sd0 || out_q !== 16'sd0) begin
      bad++;
      $display("FAIL R1: got v=%0d c=%0d i=%0d q=%0d expected all 0",
               out_valid, out_clip, out_i, out_q);
    end
    @(negedge clk); rst = 1'b0;

    // R1/R7: initial register resets to unity gain
    step(1, 500, -500, 0, 12'h000, 0, 12'h000, 7, 1, 500, -500, 0, "R1");
    // R2: known gain values, floor direction on negatives
    step(1, 1000, 1000, 1, 12'h000, 0, 12'h000, 7, 1, 1000, 1000, 0, "R2");
    step(1, 1000, -1000, 1, 12'h080, 0, 12'h000, 7, 1, 1414, -1415, 0, "R2");
    step(1, 100, -100, 1, 12'h100, 0, 12'h000, 7, 1, 200, -200, 0, "R2");
    step(1, 1, -1, 1, 12'h0FF, 0, 12'h000, 7, 1, 1, -2, 0, "R2");
    // R3: I and Q share one gain
    step(1, 3000, 3000, 1, 12'h340, 0, 12'h000, 7, 0, 0, 0, 0, "R3");
    // R4/R5: every word length, symmetric limits
    step(1, 100, -100, 1, 12'h000, 0, 12'h000, 0, 1, 7, -7, 1, "R4");
    step(1, 100, -100, 1, 12'h000, 0, 12'h000, 1, 1, 15, -15, 1, "R4");
    step(1, 100, -100, 1, 12'h000, 0, 12'h000, 2, 1, 31, -31, 1, "R4");
    step(1, 100, -100, 1, 12'h000, 0, 12'h000, 3, 1, 63, -63, 1, "R4");
    step(1, 100, -100, 1, 12'h000, 0, 12'h000, 4, 1, 100, -100, 0, "R5");
    step(1, 600, -600, 1, 12'h000, 0, 12'h000, 5, 1, 511, -511, 1, "R4");
    step(1, 600, -600, 1, 12'h000, 0, 12'h000, 6, 1, 600, -600, 0, "R5");
    step(1, 7, 5, 1, 12'h000, 0, 12'h000, 0, 1, 7, 5, 0, "R5");
    step(1, 8, 0, 1, 12'h000, 0, 12'h000, 0, 1, 7, 0, 1, "R5");
    // R4: large gain, both lanes hit the 16-bit limits
    step(1, 32767, -32768, 1, 12'hF00, 0, 12'h000, 7, 1, 32767, -32767, 1, "R4");
    idle(2);
    // R7: load in same cycle uses the old value, next sample uses the new one
    step(1, 1000, 0, 0, 12'h000, 1, 12'h080, 7, 1, 1000, 0, 0, "R7");
    step(1, 1000, 0, 0, 12'h000, 0, 12'h000, 7, 1, 1414, 0, 0, "R7");
    step(1, 1000, 0, 1, 12'h000, 0, 12'h000, 7, 1, 1000, 0, 0, "R7");
    idle(4);
    // R8: idle gives no strobe and no flag
    total++;
    if (out_valid !== 1'b0 || out_clip !== 1'b0) begin
      bad++;
      $display("FAIL R8: got v=%0d c=%0d expected 0 0", out_valid, out_clip);
    end
    // R6: back-to-back and gapped random traffic
    for (int k = 0; k < 400; k++) begin
      bit v, le, we;
      int i, q, c;
      logic [11:0] lg, wg;
      v  = ($urandom % 4) != 0;
      i  = int'($urandom % 65536) - 32768;
      q  = int'($urandom % 65536) - 32768;
      if ($urandom % 3 == 0) begin i = i / 256; q = q / 256; end
      le = ($urandom % 3) != 0;
      lg = {4'($urandom % 7), 8'($urandom)};
      we = ($urandom % 8) == 0;
      wg = {4'($urandom % 7), 8'($urandom)};
      c  = int'($urandom % 8);
      step(v, i, q, le, lg, we, wg, c, 0, 0, 0, 0, "R6");
    end
    idle(6);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R6: got %0d pending outputs expected 0", sb.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule